// File: doc/BRIEF.md
# Chained shift register IO scanner

This block drives a daisy chain of serial-to-parallel output registers (LED drivers) and parallel-to-serial input registers (button readers). Both chains share one serial clock and one latch clock. On a programmable period counted in milliseconds, the block runs one scan. The scan opens with a low pulse on the latch clock to capture the button levels. It then shifts every configured byte out and in at the same time. A second latch pulse transfers the shifted data to the LED outputs. An optional excitation pulse for a capacitive touch sensor can wrap the capture strobe. The pulse length is a programmable number of phase steps.

A host reads and writes a small register space through a single-cycle port. The address is split into a 2-bit bank (`host_addr[5:4]`) and a 4-bit index:

| Bank | Contents | Host write |
|---|---|---|
| 0 | Output bytes | Stores the byte |
| 1 | Captured input bytes | Ignored |
| 2 | Sticky changed flags | Write-1-to-clear |
| 3 | Index 0: register count; index 1: period in ms; index 2: touch setting | Stores the setting |

Bank 3 indexes other than 0, 1 and 2 read 0. After every received byte, the flag byte at that index gains the bits in which the new input differs from the previous one.

Top module: `srscan_top`

## Requirements
- R1: After reset the pins are idle: `sr_sclk`=1, `sr_rclk`=1, `sr_dout`=1, `touch_pin`=0. The register count reads 16, the period reads 1 and the touch setting reads 0.
- R2: A written register count of 16 or more (any nonzero upper nibble) is stored as 16; smaller values are stored as written. A scan shifts exactly that many bytes, 8 serial clock pulses per byte.
- R3: A written period of 0 is stored as 1. When a scan is shorter than the period, successive scans start exactly period × TICK_DIV system clocks apart.
- R4: Each scan opens with a low pulse on `sr_rclk` followed by a return high. This happens before the first falling edge of `sr_sclk`, and `sr_sclk` is never low while `sr_rclk` is low.
- R5: With a nonzero touch setting S, `touch_pin` rises while both clocks are high and stays high for S × PHASE_CLKS clocks before `sr_rclk` falls. It is low again when `sr_rclk` returns high. `touch_oe` is 1 exactly when the setting is nonzero.
- R6: Output bytes are sent from index count−1 down to index 0. Input bytes are stored from index 0 upward.
- R7: Within a byte, output bit 0 is sent first and bit 7 last. The first input bit sampled is stored in bit 7 and the last in bit 0.
- R8: Every serial clock low phase and every latch-clock phase lasts PHASE_CLKS (at least 2) system clocks. Data-out changes and input sampling happen only while `sr_sclk` is low.
- R9: After each byte is received, its flag byte becomes old flags OR (new input XOR previous input), and the input byte is replaced by the new one.
- R10: Each scan ends with a low pulse on `sr_rclk`. `sr_dout` is high when `sr_rclk` rises, and both clocks and `sr_dout` stay high between scans.
- R11: A host write to bank 2 clears exactly the bits written as 1. A host write to bank 1 leaves the input byte unchanged. A byte written to bank 0 is sent on the next scan that starts after the write.
- R12: A scan request that arrives while a scan runs is dropped. Scans start only on millisecond tick boundaries, so the distance between scan starts is a multiple of TICK_DIV.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_addr | input | 6 | Bank in bits 5:4, index in bits 3:0 |
| host_we | input | 1 | Host write strobe |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Read data for `host_addr` (combinational) |
| sr_sclk | output | 1 | Shared serial clock |
| sr_rclk | output | 1 | Shared latch clock (capture and LED transfer) |
| sr_dout | output | 1 | Serial data to the output chain |
| sr_din | input | 1 | Serial data from the input chain |
| touch_pin | output | 1 | Touch-sensor excitation level |
| touch_oe | output | 1 | Touch-sensor pin drive enable |

## Verification
The assertions check the pin protocol on every cycle. They cover the idle levels after reset and the fact that the two clocks are never low together. They also check the minimum length of serial clock phases, that shifting starts only after the capture strobe with the touch pulse already ended, and that data-out is high at every latch-clock rise. Only the bench's scenarios can show the data itself:

- byte and bit ordering in both directions;
- changed-flag accumulation and host clearing;
- clamping of the count and the period;
- the touch pulse length;
- spacing of scan starts, and the dropping of requests during long scans.

// File: rtl/srscan_pkg.sv
// Shared types for the shift register scanner.
// Assumes: a single clock domain; all users import this package.
package srscan_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,   // pins idle, waiting for a scan request
        ST_TOUCH,  // touch pin high, counting wait steps
        ST_LATLO,  // capture strobe low
        ST_LATHI,  // capture strobe back high
        ST_LOAD,   // fetch next output byte
        ST_BITLO,  // serial clock low: data-out set, input sampled at end
        ST_BITHI,  // serial clock high
        ST_STORE,  // write received byte into the input/flag files
        ST_FINLO,  // output transfer strobe low
        ST_FINHI   // output transfer strobe back high
    } scan_state_t;

    localparam logic [1:0] BANK_OUT = 2'd0;
    localparam logic [1:0] BANK_IN  = 2'd1;
    localparam logic [1:0] BANK_CHG = 2'd2;
    localparam logic [1:0] BANK_CFG = 2'd3;

endpackage

// File: rtl/srscan_tick.sv
// Scan tick generator: a free-running millisecond prescaler followed by
// a period counter that emits a one-clock scan request every `period` ms.
// Assumes: TICK_DIV >= 2 system clocks per millisecond; period >= 1.
module srscan_tick #(
    parameter int unsigned TICK_DIV = 50000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] period,
    output logic       scan_req
);
    localparam int unsigned MS_W = $clog2(TICK_DIV);

    logic [MS_W-1:0] ms_cnt;
    logic [7:0]      per_cnt;
    logic            ms_pulse;

    assign ms_pulse = (ms_cnt == MS_W'(TICK_DIV - 1));

    // Millisecond prescaler, wraps every TICK_DIV clocks.
    always_ff @(posedge clk) begin
        if (!rst_n)        ms_cnt <= '0;
        else if (ms_pulse) ms_cnt <= '0;
        else               ms_cnt <= ms_cnt + 1'b1;
    end

    // Period counter: raises the scan request once per `period` ms ticks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            per_cnt  <= '0;
            scan_req <= 1'b0;
        end else begin
            scan_req <= 1'b0;
            if (ms_pulse) begin
                if ({1'b0, per_cnt} + 9'd1 >= {1'b0, period}) begin
                    per_cnt  <= '0;
                    scan_req <= 1'b1;
                end else begin
                    per_cnt <= per_cnt + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/srscan_regs.sv
// Register files and settings of the scanner: output bytes, captured input
// bytes, sticky changed flags and the three configuration values. Serves
// the host port and the scan engine's byte read/store ports.
// Assumes: MAX_REGS is a power of two and at most 255.
module srscan_regs
    import srscan_pkg::*;
#(
    parameter int unsigned MAX_REGS = 16,
    parameter int unsigned IDX_W    = $clog2(MAX_REGS),
    parameter int unsigned CNT_W    = $clog2(MAX_REGS + 1),
    parameter int unsigned AW       = IDX_W + 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [AW-1:0]    host_addr,
    input  logic             host_we,
    input  logic [7:0]       host_wdata,
    output logic [7:0]       host_rdata,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [7:0]       rd_byte,
    input  logic             upd_en,
    input  logic [IDX_W-1:0] upd_idx,
    input  logic [7:0]       upd_byte,
    output logic [CNT_W-1:0] cfg_count,
    output logic [7:0]       cfg_period,
    output logic [7:0]       cfg_sens
);
    logic [1:0]       bank;
    logic [IDX_W-1:0] idx;
    logic [7:0]       out_q [MAX_REGS];
    logic [7:0]       in_q  [MAX_REGS];
    logic [7:0]       chg_q [MAX_REGS];

    assign bank    = host_addr[AW-1:AW-2];
    assign idx     = host_addr[IDX_W-1:0];
    assign rd_byte = out_q[rd_idx];

    // Output byte file, written only by the host.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < int'(MAX_REGS); i++) out_q[i] <= '0;
        end else if (host_we && bank == BANK_OUT) begin
            out_q[idx] <= host_wdata;
        end
    end

    // One input byte and one flag byte per chain position.
    for (genvar g = 0; g < int'(MAX_REGS); g++) begin : g_entry
        logic       hit_upd;
        logic [7:0] clr_mask;

        assign hit_upd  = upd_en && (upd_idx == IDX_W'(g));
        assign clr_mask = (host_we && bank == BANK_CHG && idx == IDX_W'(g))
                          ? host_wdata : 8'h00;

        // Input byte replaced by each newly received byte.
        always_ff @(posedge clk) begin
            if (!rst_n)       in_q[g] <= '0;
            else if (hit_upd) in_q[g] <= upd_byte;
        end

        // Flags gather input differences; host write-1 clears bits.
        always_ff @(posedge clk) begin
            if (!rst_n) chg_q[g] <= '0;
            else        chg_q[g] <= (chg_q[g] & ~clr_mask)
                                    | (hit_upd ? (upd_byte ^ in_q[g]) : 8'h00);
        end
    end

    // Configuration values with their write-time clamping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_count  <= CNT_W'(MAX_REGS);
            cfg_period <= 8'd1;
            cfg_sens   <= 8'd0;
        end else if (host_we && bank == BANK_CFG) begin
            case (idx)
                IDX_W'(0): cfg_count  <= (host_wdata >= 8'(MAX_REGS))
                                         ? CNT_W'(MAX_REGS) : host_wdata[CNT_W-1:0];
                IDX_W'(1): cfg_period <= (host_wdata == 8'd0) ? 8'd1 : host_wdata;
                IDX_W'(2): cfg_sens   <= host_wdata;
                default: ;
            endcase
        end
    end

    // Host read multiplexer.
    always_comb begin
        host_rdata = 8'h00;
        case (bank)
            BANK_OUT: host_rdata = out_q[idx];
            BANK_IN:  host_rdata = in_q[idx];
            BANK_CHG: host_rdata = chg_q[idx];
            default: begin
                if (idx == IDX_W'(0))      host_rdata = 8'(cfg_count);
                else if (idx == IDX_W'(1)) host_rdata = cfg_period;
                else if (idx == IDX_W'(2)) host_rdata = cfg_sens;
            end
        endcase
    end

endmodule

// File: rtl/srscan_engine.sv
// Scan sequencer. On a request while idle, it runs the optional touch
// pulse and the capture strobe. It then shifts cfg_count bytes (outputs
// from the top index down, inputs from index 0 up) and ends with the
// output transfer strobe.
// Assumes: PHASE_CLKS >= 2; sr_din is stable when sampled, at the end of
// each serial-clock low phase.
module srscan_engine
    import srscan_pkg::*;
#(
    parameter int unsigned PHASE_CLKS = 4,
    parameter int unsigned IDX_W      = 4,
    parameter int unsigned CNT_W      = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scan_req,
    input  logic [CNT_W-1:0] cfg_count,
    input  logic [7:0]       cfg_sens,
    output logic [IDX_W-1:0] rd_idx,
    input  logic [7:0]       rd_byte,
    output logic             upd_en,
    output logic [IDX_W-1:0] upd_idx,
    output logic [7:0]       upd_byte,
    output logic             sr_sclk,
    output logic             sr_rclk,
    output logic             sr_dout,
    input  logic             sr_din,
    output logic             touch_pin
);
    localparam int unsigned PH_W = $clog2(PHASE_CLKS);

    scan_state_t      state;
    logic [PH_W-1:0]  ph;
    logic             timed, step_end;
    logic [CNT_W-1:0] n_q, bcnt, ridx;
    logic [2:0]       bit_q;
    logic [7:0]       tcnt, obyte, shreg;

    assign timed    = state inside {ST_TOUCH, ST_LATLO, ST_LATHI, ST_BITLO,
                                    ST_BITHI, ST_FINLO, ST_FINHI};
    assign step_end = (ph == PH_W'(PHASE_CLKS - 1));
    assign ridx     = n_q - CNT_W'(1) - bcnt;
    assign rd_idx   = ridx[IDX_W-1:0];
    assign upd_en   = (state == ST_STORE);
    assign upd_idx  = bcnt[IDX_W-1:0];
    assign upd_byte = shreg;

    // Phase timer: counts system clocks within each timed step.
    always_ff @(posedge clk) begin
        if (!rst_n) ph <= '0;
        else        ph <= (timed && !step_end) ? ph + 1'b1 : '0;
    end

    // Scan state machine and pin drivers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            n_q       <= '0;
            bcnt      <= '0;
            bit_q     <= '0;
            tcnt      <= '0;
            obyte     <= '0;
            shreg     <= '0;
            sr_sclk   <= 1'b1;
            sr_rclk   <= 1'b1;
            sr_dout   <= 1'b1;
            touch_pin <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: if (scan_req) begin
                    n_q  <= cfg_count;
                    bcnt <= '0;
                    if (cfg_sens != 8'd0) begin
                        touch_pin <= 1'b1;
                        tcnt      <= cfg_sens;
                        state     <= ST_TOUCH;
                    end else begin
                        sr_rclk <= 1'b0;
                        state   <= ST_LATLO;
                    end
                end
                ST_TOUCH: if (step_end) begin
                    if (tcnt == 8'd1) begin
                        sr_rclk <= 1'b0;
                        state   <= ST_LATLO;
                    end else begin
                        tcnt <= tcnt - 1'b1;
                    end
                end
                ST_LATLO: if (step_end) begin
                    sr_rclk   <= 1'b1;
                    touch_pin <= 1'b0;
                    state     <= ST_LATHI;
                end
                ST_LATHI: if (step_end) begin
                    if (n_q == '0) begin
                        sr_rclk <= 1'b0;
                        state   <= ST_FINLO;
                    end else begin
                        state <= ST_LOAD;
                    end
                end
                ST_LOAD: begin
                    obyte   <= rd_byte;
                    sr_dout <= rd_byte[0];
                    bit_q   <= '0;
                    sr_sclk <= 1'b0;
                    state   <= ST_BITLO;
                end
                ST_BITLO: if (step_end) begin
                    shreg   <= {shreg[6:0], sr_din};
                    sr_sclk <= 1'b1;
                    state   <= ST_BITHI;
                end
                ST_BITHI: if (step_end) begin
                    if (bit_q == 3'd7) begin
                        state <= ST_STORE;
                    end else begin
                        bit_q   <= bit_q + 1'b1;
                        sr_dout <= obyte[3'(bit_q + 3'd1)];
                        sr_sclk <= 1'b0;
                        state   <= ST_BITLO;
                    end
                end
                ST_STORE: begin
                    bcnt <= bcnt + 1'b1;
                    if (CNT_W'(bcnt + 1'b1) == n_q) begin
                        sr_rclk <= 1'b0;
                        state   <= ST_FINLO;
                    end else begin
                        state <= ST_LOAD;
                    end
                end
                ST_FINLO: if (step_end) begin
                    sr_rclk <= 1'b1;
                    sr_dout <= 1'b1;
                    state   <= ST_FINHI;
                end
                ST_FINHI: if (step_end) state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/srscan_top.sv
// Top of the chained shift register scanner: tick generator, register
// files and scan engine. touch_oe enables the touch pin driver whenever
// the touch setting is nonzero.
// Assumes: external chains capture inputs while the latch clock is low and
// update their LED outputs on its rising edge.
module srscan_top #(
    parameter int unsigned TICK_DIV   = 50000,
    parameter int unsigned PHASE_CLKS = 4,
    parameter int unsigned MAX_REGS   = 16,
    localparam int unsigned IDX_W     = $clog2(MAX_REGS),
    localparam int unsigned CNT_W     = $clog2(MAX_REGS + 1),
    localparam int unsigned AW        = IDX_W + 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] host_addr,
    input  logic          host_we,
    input  logic [7:0]    host_wdata,
    output logic [7:0]    host_rdata,
    output logic          sr_sclk,
    output logic          sr_rclk,
    output logic          sr_dout,
    input  logic          sr_din,
    output logic          touch_pin,
    output logic          touch_oe
);
    logic             scan_req, upd_en;
    logic [IDX_W-1:0] rd_idx, upd_idx;
    logic [7:0]       rd_byte, upd_byte, cfg_period, cfg_sens;
    logic [CNT_W-1:0] cfg_count;

    assign touch_oe = (cfg_sens != 8'd0);

    srscan_tick #(.TICK_DIV(TICK_DIV)) u_tick (
        .clk(clk), .rst_n(rst_n), .period(cfg_period), .scan_req(scan_req)
    );

    srscan_regs #(.MAX_REGS(MAX_REGS), .IDX_W(IDX_W), .CNT_W(CNT_W), .AW(AW)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .host_addr(host_addr), .host_we(host_we), .host_wdata(host_wdata),
        .host_rdata(host_rdata),
        .rd_idx(rd_idx), .rd_byte(rd_byte),
        .upd_en(upd_en), .upd_idx(upd_idx), .upd_byte(upd_byte),
        .cfg_count(cfg_count), .cfg_period(cfg_period), .cfg_sens(cfg_sens)
    );

    srscan_engine #(.PHASE_CLKS(PHASE_CLKS), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_engine (
        .clk(clk), .rst_n(rst_n), .scan_req(scan_req),
        .cfg_count(cfg_count), .cfg_sens(cfg_sens),
        .rd_idx(rd_idx), .rd_byte(rd_byte),
        .upd_en(upd_en), .upd_idx(upd_idx), .upd_byte(upd_byte),
        .sr_sclk(sr_sclk), .sr_rclk(sr_rclk), .sr_dout(sr_dout),
        .sr_din(sr_din), .touch_pin(touch_pin)
    );

endmodule

// File: rtl/srscan_chk.sv
// Pin-protocol checker for srscan_top, attached by bind.
// Assumes: PHASE_CLKS >= 2.
module srscan_chk (
    input logic clk,
    input logic rst_n,
    input logic sr_sclk,
    input logic sr_rclk,
    input logic sr_dout,
    input logic touch_pin
);
    // R1: pins idle on the first cycle after reset.
    a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (sr_sclk && sr_rclk && sr_dout && !touch_pin));

    // R4: the serial clock is never low while the latch clock is low.
    a_r4_no_clock_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        !(!sr_sclk && !sr_rclk));

    // R4, R5: shifting starts only after the strobe, with the touch pulse over.
    a_r4_shift_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sr_sclk) |-> (sr_rclk && !touch_pin));

    // R5: the touch pulse starts while both clocks are idle high.
    a_r5_touch_starts_idle: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(touch_pin) |-> (sr_rclk && sr_sclk));

    // R8: a serial-clock low phase lasts at least two clocks.
    a_r8_sclk_low_hold: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sr_sclk) |=> !sr_sclk);

    // R8: a serial-clock high phase lasts at least two clocks.
    a_r8_sclk_high_hold: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sr_sclk) |=> sr_sclk);

    // R10: data-out is high whenever the latch clock rises.
    a_r10_dout_high_at_latch: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sr_rclk) |-> sr_dout);

endmodule

bind srscan_top srscan_chk u_chk (
    .clk(clk), .rst_n(rst_n), .sr_sclk(sr_sclk), .sr_rclk(sr_rclk),
    .sr_dout(sr_dout), .touch_pin(touch_pin)
);

// File: tb/srscan_top_test.sv
module srscan_top_test;
    localparam int CLK_PERIOD = 10;
    localparam int TICK       = 20;
    localparam int PH         = 2;
    localparam int MAXR       = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] host_addr = '0;
    logic       host_we = 1'b0;
    logic [7:0] host_wdata = '0;
    logic [7:0] host_rdata;
    logic       sr_sclk, sr_rclk, sr_dout, touch_pin, touch_oe;
    logic       sr_din = 1'b0;

    srscan_top #(.TICK_DIV(TICK), .PHASE_CLKS(PH), .MAX_REGS(MAXR)) uut (
        .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_we(host_we),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .sr_sclk(sr_sclk), .sr_rclk(sr_rclk), .sr_dout(sr_dout), .sr_din(sr_din),
        .touch_pin(touch_pin), .touch_oe(touch_oe)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    int n_checks = 0, n_fail = 0;

    task automatic check(string req, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Behavioural model of the chains and of the register files.
    logic [7:0] in_pat [MAXR];
    logic [7:0] scan_pat [MAXR];
    logic [7:0] out_mdl [MAXR];
    logic [7:0] in_mdl [MAXR];
    logic [7:0] chg_mdl [MAXR];
    bit  in_bits[$];
    bit  sent[$];
    bit  latched[$];
    int  m_count = 16, m_sens = 0, scan_n = 0;
    int  scans_done = 0, cyc = 0, last_start = 0, gap = 0;
    int  touch_run = 0, touch_len = 0, touch_at_latch = 0, touch_after = 1;
    int  phase_sel = 0, dout_end = 0, order_err = 0, idle_err = 0;
    int  low_run = 0, min_low = 1000;
    bit  in_scan = 0;
    logic p_sclk = 1'b1, p_rclk = 1'b1;

    // Per-clock reference: follow pin edges, drive din, compare idle levels.
    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            if (p_rclk && !sr_rclk && !in_scan) begin
                in_scan = 1;
                phase_sel = 0;
                sent.delete();
                in_bits.delete();
                touch_at_latch = int'(touch_pin);
                touch_len = touch_run;
                gap = cyc - last_start;
                last_start = cyc;
                scan_n = m_count;
                for (int j = 0; j < MAXR; j++) scan_pat[j] = in_pat[j];
                for (int j = 0; j < scan_n; j++)
                    for (int b = 7; b >= 0; b--) in_bits.push_back(in_pat[j][b]);
            end
            if (!p_rclk && sr_rclk && in_scan) begin
                if (phase_sel == 0) begin
                    touch_after = int'(touch_pin);
                    phase_sel = 1;
                end else begin
                    dout_end = int'(sr_dout);
                    latched = sent;
                    for (int j = 0; j < scan_n; j++) begin
                        chg_mdl[j] = chg_mdl[j] | (in_mdl[j] ^ scan_pat[j]);
                        in_mdl[j]  = scan_pat[j];
                    end
                    in_scan = 0;
                    scans_done++;
                end
            end
            if (p_sclk && !sr_sclk && !(in_scan && phase_sel == 1)) order_err++;
            if (!p_sclk && sr_sclk) begin
                sent.push_back(sr_dout);
                if (in_bits.size() > 0) void'(in_bits.pop_front());
                if (low_run < min_low) min_low = low_run;
            end
            low_run = sr_sclk ? 0 : low_run + 1;
            touch_run = touch_pin ? touch_run + 1 : 0;
            if (!in_scan && !(sr_sclk && sr_rclk && sr_dout)) idle_err++;
            if (touch_oe != (m_sens != 0)) idle_err++;
        end
        sr_din = (in_bits.size() > 0) ? in_bits[0] : 1'b0;
        p_sclk = sr_sclk;
        p_rclk = sr_rclk;
    end

    task automatic hwrite(logic [5:0] a, logic [7:0] d);
        @(negedge clk);
        host_addr = a; host_wdata = d; host_we = 1'b1;
        @(posedge clk);
        #1;
        if (a[5:4] == 2'd0) out_mdl[a[3:0]] = d;
        if (a[5:4] == 2'd2) chg_mdl[a[3:0]] = chg_mdl[a[3:0]] & ~d;
        if (a == 6'h30) m_count = (d >= 8'd16) ? 16 : int'(d);
        if (a == 6'h32) m_sens = int'(d);
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic hread(logic [5:0] a, output int d);
        @(negedge clk);
        host_addr = a;
        #1 d = int'(host_rdata);
    endtask

    task automatic wait_scans(int k);
        int target = scans_done + k;
        int t = 0;
        while (scans_done < target && t < 30000) begin
            @(negedge clk);
            t++;
        end
        check("watchdog scan wait", int'(scans_done >= target), 1);
    endtask

    // Check one full scan: sent stream, input file and flag file.
    task automatic check_scan(string tag);
        int v;
        check({tag, " R2 bits per scan"}, latched.size(), 8 * m_count);
        for (int p = 0; p < m_count && latched.size() == 8 * m_count; p++) begin
            logic [7:0] sb;
            for (int b = 0; b < 8; b++) sb[b] = latched[8 * p + b];
            check({tag, " R6 R7 sent byte"}, int'(sb), int'(out_mdl[m_count - 1 - p]));
        end
        for (int j = 0; j < m_count; j++) begin
            hread(6'h10 + 6'(j), v);
            check({tag, " R6 R7 input byte"}, v, int'(in_mdl[j]));
            hread(6'h20 + 6'(j), v);
            check({tag, " R9 changed flags"}, v, int'(chg_mdl[j]));
        end
        check({tag, " R10 dout high at end"}, dout_end, 1);
        check({tag, " R4 shift after strobe"}, order_err, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 190000);
        n_fail++;
        n_checks++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        int v;
        for (int j = 0; j < MAXR; j++) begin
            in_pat[j] = '0; out_mdl[j] = '0; in_mdl[j] = '0; chg_mdl[j] = '0;
        end
        repeat (4) @(negedge clk);
        check("R1 sclk idle", int'(sr_sclk), 1);
        check("R1 rclk idle", int'(sr_rclk), 1);
        check("R1 dout idle", int'(sr_dout), 1);
        check("R1 touch idle", int'(touch_pin), 0);
        rst_n = 1'b1;
        hread(6'h30, v); check("R1 count default", v, 16);
        hread(6'h31, v); check("R1 period default", v, 1);
        hread(6'h32, v); check("R1 touch default", v, 0);

        hwrite(6'h30, 8'h23); hread(6'h30, v); check("R2 clamp 0x23", v, 16);
        hwrite(6'h30, 8'h10); hread(6'h30, v); check("R2 clamp 0x10", v, 16);
        hwrite(6'h30, 8'h0F); hread(6'h30, v); check("R2 keep 0x0F", v, 15);
        hwrite(6'h31, 8'h00); hread(6'h31, v); check("R3 period zero", v, 1);

        // Scenario A: three bytes, 10 ms period, no touch pulse.
        hwrite(6'h30, 8'd3);
        hwrite(6'h31, 8'd10);
        hwrite(6'h00, 8'hA5); hwrite(6'h01, 8'h3C); hwrite(6'h02, 8'h81);
        in_pat[0] = 8'h96; in_pat[1] = 8'h0F; in_pat[2] = 8'hE1;
        wait_scans(3);
        check_scan("A");
        check("A R3 scan spacing", gap, 10 * TICK);
        check("A R5 no touch pulse", touch_len, 0);
        check("A R8 sclk low phase", min_low, PH);

        // R11: input file ignores writes; flag file clears written ones.
        hwrite(6'h10, 8'hFF);
        hread(6'h10, v); check("R11 input write ignored", v, int'(in_mdl[0]));
        hwrite(6'h20, 8'h0F);
        hread(6'h20, v); check("R11 flag clear", v, int'(chg_mdl[0]));

        // Scenario B: new inputs and outputs, flags accumulate.
        hwrite(6'h00, 8'h5A); hwrite(6'h02, 8'h7E);
        in_pat[0] = 8'h69; in_pat[1] = 8'hF0; in_pat[2] = 8'hE3;
        wait_scans(3);
        check_scan("B R11");

        // Scenario C: count clamped to 16, touch pulse, back-to-back requests.
        hwrite(6'h32, 8'd3);
        hwrite(6'h31, 8'd1);
        hwrite(6'h30, 8'h40);
        for (int j = 0; j < MAXR; j++) begin
            hwrite(6'(j), 8'(j * 17 + 3));
            in_pat[j] = 8'(j * 29 + 5);
        end
        wait_scans(3);
        check_scan("C");
        check("C R5 touch high at strobe", touch_at_latch, 1);
        check("C R5 touch length", touch_len, 3 * PH);
        check("C R5 touch low after strobe", touch_after, 0);
        check("C R12 start on tick grid", gap % TICK, 0);
        check("C R12 busy requests dropped", int'(gap > 16 * 8 * 2 * PH), 1);
        check("R1 R10 idle levels every clock", idle_err, 0);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule